// File: doc/BRIEF.md
# Subcarrier Hue Phase Offset Generator

This block keeps the running phase of the colour subcarrier used by composite and chroma outputs. Each clock a 32-bit accumulator advances by a programmable frequency increment and wraps modulo 2^32. The registered output phase word goes to an external sine/cosine lookup.

During active video, an 8-bit hue code shifts the output phase. The code is an offset-binary number centred on 0x80. Each step is 1/2048 of a turn, about 0.1758 degrees, so the full span is roughly plus or minus 22.5 degrees. During the colour burst the output always carries the unshifted accumulator phase. The receiver uses the burst as its reference, so a shift applied only to the picture becomes a visible hue change. The lowest legal code depends on the video standard. In the 625-line (PAL) mode, code 0x00 is clamped to 0x01. In the 525-line (NTSC) mode, code 0x00 is legal.

Top module: `hue_phase_gen`

## Requirements
- R1: After reset the accumulator and `phase_out` are zero. At each rising clock edge out of reset, the accumulator advances by `phase_inc` modulo 2^32.
- R2: The output is registered with one cycle of latency. When the offset is applied, `phase_out` equals the accumulator value before the edge, plus (effective code − 128) placed at bit 21, modulo 2^32. One code step is 2^21, which is 1/2048 turn.
- R3: Code 0x80 gives zero offset. Code 0x97 gives +23 steps (about +4 degrees). Code 0x69 gives −23 steps (about −4 degrees).
- R4: When `pal_mode`=1, code 0x00 is treated as 0x01, giving −127 steps. When `pal_mode`=0, code 0x00 gives −128 steps. Codes 0x01 to 0xFF are used unchanged in both modes.
- R5: When `hue_en`=0, the offset is zero whatever the hue code.
- R6: When `burst_gate`=1, `phase_out` is the raw accumulator phase, even if `active_gate` and `hue_en` are also high.
- R7: When `active_gate`=0, `phase_out` is the raw accumulator phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_inc | input | 32 | Per-cycle phase increment |
| hue_code | input | 8 | Hue code, offset binary, 0x80 = no shift |
| hue_en | input | 1 | Hue offset enable |
| pal_mode | input | 1 | 1 = PAL lower limit 0x01, 0 = NTSC lower limit 0x00 |
| burst_gate | input | 1 | High during the colour burst |
| active_gate | input | 1 | High during active video |
| phase_out | output | 32 | Phase word to the sine/cosine lookup |

## Verification
The hardest case to reach is the PAL clamp. It only shows when code 0x00 arrives with the enable on, active video high and burst low, in one particular mode. A bias error there moves the phase by just one step out of 2048. The bench sweeps every hue code against every combination of mode, enable and both gates. It feeds a different, large increment each cycle, so the offset addition also crosses the 2^32 wrap point. Explicit wrap vectors then check the accumulator on its own.

// File: rtl/hue_phase_gen.sv
module hue_phase_gen #(
  parameter int ACC_W  = 32,
  parameter int HUE_W  = 8,
  parameter int STEP_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] phase_inc,
  input  logic [HUE_W-1:0] hue_code,
  input  logic             hue_en,
  input  logic             pal_mode,
  input  logic             burst_gate,
  input  logic             active_gate,
  output logic [ACC_W-1:0] phase_out
);
  localparam int SHIFT = ACC_W - STEP_W;
  localparam logic [HUE_W:0] CENTRE = (HUE_W+1)'(1) << (HUE_W - 1);

  logic [ACC_W-1:0]  acc;
  logic [HUE_W-1:0]  code_eff;
  logic [HUE_W:0]    delta;
  logic [STEP_W-1:0] delta_top;
  logic [ACC_W-1:0]  offset;
  logic              apply;

  assign code_eff  = (pal_mode && hue_code == '0) ? HUE_W'(1) : hue_code;
  assign delta     = {1'b0, code_eff} - CENTRE;
  assign delta_top = {{(STEP_W-HUE_W-1){delta[HUE_W]}}, delta};
  assign offset    = {delta_top, {SHIFT{1'b0}}};
  assign apply     = hue_en & active_gate & ~burst_gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      phase_out <= '0;
    end else begin
      acc       <= acc + phase_inc;
      phase_out <= acc + (apply ? offset : '0);
    end
  end
endmodule

module hue_phase_gen_chk #(
  parameter int ACC_W  = 32,
  parameter int HUE_W  = 8,
  parameter int STEP_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] phase_inc,
  input logic [HUE_W-1:0] hue_code,
  input logic             hue_en,
  input logic             pal_mode,
  input logic             burst_gate,
  input logic             active_gate,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] phase_out
);
  localparam int SHIFT = ACC_W - STEP_W;
  localparam logic [ACC_W-1:0] MIN_OFF = ~((ACC_W'(1) << (HUE_W - 1 + SHIFT)) - ACC_W'(1));

  p_acc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> acc == $past(acc) + $past(phase_inc));

  p_step_grain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((phase_out - $past(acc)) & ((ACC_W'(1) << SHIFT) - ACC_W'(1))) == '0);

  p_pal_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pal_mode)) |-> (phase_out - $past(acc)) != MIN_OFF);

  p_disabled_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(hue_en)) |-> phase_out == $past(acc));

  p_burst_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(burst_gate)) |-> phase_out == $past(acc));

  p_inactive_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(active_gate)) |-> phase_out == $past(acc));
endmodule

bind hue_phase_gen hue_phase_gen_chk #(.ACC_W(ACC_W), .HUE_W(HUE_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .hue_code(hue_code),
  .hue_en(hue_en), .pal_mode(pal_mode), .burst_gate(burst_gate),
  .active_gate(active_gate), .acc(acc), .phase_out(phase_out)
);

// File: tb/test_hue_phase_gen.sv
module test_hue_phase_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] phase_inc = '0;
  logic [7:0]  hue_code = 8'h80;
  logic        hue_en = 1'b0, pal_mode = 1'b0, burst_gate = 1'b0, active_gate = 1'b0;
  logic [31:0] phase_out;

  int vectors = 0, errors = 0;
  logic [31:0] model_acc = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hue_phase_gen i_hue_phase_gen (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .hue_code(hue_code),
    .hue_en(hue_en), .pal_mode(pal_mode), .burst_gate(burst_gate),
    .active_gate(active_gate), .phase_out(phase_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic [31:0] inc, logic [7:0] code, bit en, bit pal, bit burst, bit act);
    int eff, d;
    logic [31:0] exp;
    string tag;
    @(negedge clk);
    phase_inc = inc; hue_code = code; hue_en = en; pal_mode = pal;
    burst_gate = burst; active_gate = act;
    eff = (pal && code == 8'h00) ? 1 : int'(code);
    d = eff - 128;
    exp = model_acc + ((en && act && !burst) ? 32'(d * 2097152) : 32'h0);
    if (burst) tag = "R6";
    else if (!act) tag = "R7";
    else if (!en) tag = "R5";
    else if (code == 8'h00) tag = "R4";
    else if (code == 8'h80 || code == 8'h97 || code == 8'h69) tag = "R3";
    else tag = "R2";
    @(posedge clk); #1;
    check(tag, phase_out, exp);
    model_acc = model_acc + inc;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset phase", phase_out, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    // R3 spot values: +23 and -23 steps
    step(32'h0, 8'h97, 1, 0, 0, 1);
    check("R3 +4deg", phase_out, 32'(23 * 2097152));
    step(32'h0, 8'h69, 1, 1, 0, 1);
    check("R3 -4deg", phase_out, 32'(-23 * 2097152));
    // R4 clamp directly
    step(32'h0, 8'h00, 1, 1, 0, 1);
    check("R4 pal floor", phase_out, 32'(-127 * 2097152));
    step(32'h0, 8'h00, 1, 0, 0, 1);
    check("R4 ntsc floor", phase_out, 32'(-128 * 2097152));
    // R1 wrap of accumulator
    step(32'hFFFF_FFF0, 8'h80, 0, 0, 0, 0);
    step(32'h0000_0020, 8'h80, 0, 0, 0, 0);
    step(32'h0, 8'h80, 0, 0, 0, 0);
    check("R1 wrap", phase_out, 32'h0000_0010);
    for (int c = 0; c < 256; c++)
      for (int m = 0; m < 16; m++)
        step(32'h9E37_79B9 * 32'(c * 16 + m + 1), 8'(c), m[0], m[1], m[2], m[3]);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule